// File: doc/BRIEF.md
# Single-Slope PWM Timer with Selectable Period

This block is a free-running up-counter that climbs from zero to a selected ceiling and then drops back to zero, in a sawtooth. Two compare channels watch the counter and shape a pulse-width-modulated bit each. The counter moves only on cycles where the tick input is high, so an external prescaler sets the rate. The ceiling is chosen by a 4-bit mode code. It can be a fixed 8, 9 or 10-bit limit, a period register that takes effect immediately, or the active value of compare channel A.

Both compare registers are written through a holding stage. The value that is actually compared is refreshed only when the counter wraps, so a duty or period change never tears a cycle that is already running. The period register has no holding stage. Sticky event flags record wraps, compare hits and period-register wraps until they are cleared by a write-one pulse.

Top module: `pwm_timer`

## Requirements
- R1: While rst_ni is low, count_o, wave_a_o, wave_b_o and all four flags are 0. The period register and both holding and active compare values are also 0.
- R2: On a cycle with tick_i high, the counter goes to 0 if it equals the ceiling and otherwise increments by one, rolling over from 0xFFFF to 0. With tick_i low it holds. The ceiling is 0x00FF for mode 0x5, 0x01FF for 0x6, 0x03FF for 0x7, the period register for 0xE, the active compare A value for 0xF, and 0xFFFF for any other code.
- R3: ovf_flag_o is set by the edge of a tick on which the counter equals the ceiling. Setting it is called a wrap. The flag stays set until a cycle with flag_clr_i[0] high. If a set and a clear fall on the same edge, the set wins.
- R4: cmpa_flag_o and cmpb_flag_o are set by a tick on which the counter equals that channel's active compare value. They are cleared by flag_clr_i[1] and flag_clr_i[2] respectively, and a set wins over a clear.
- R5: cap_flag_o is set on a wrap only in mode 0xE, and is cleared by flag_clr_i[3].
- R6: In modes 0x5, 0x6 and 0x7, a compare write keeps only the low 8, 9 or 10 bits of wdata_i. The bits above are stored as zero.
- R7: A compare write (cmp_a_we_i or cmp_b_we_i) lands in a holding register. On a wrap, the active value is loaded from the holding value that was present before that edge.
- R8: period_we_i loads the period register on the next edge. If the counter is already above the new ceiling, it runs up to 0xFFFF and rolls to 0. That rollover is not a wrap: no flag is set, no compare value is loaded and no output is set or cleared.
- R9: With output code 3 (non-inverting), a wrap drives the wave high and a compare hit drives it low. With code 2 (inverting), a wrap drives it low and a hit drives it high. When both happen on the same tick, the wrap wins. Without either event the wave holds.
- R10: In the non-inverting code, a compare value of 0 gives a wave high for exactly one count in each TOP+1 counts, and a compare value equal to the ceiling gives a wave that stays high.
- R11: In mode 0xF with output code 1, wave_a_o inverts on every compare A hit. It has a period of 2(TOP+1) counts, and inverts on every tick when compare A is 0.
- R12: Output code 0, and code 1 on channel B or on channel A outside mode 0xF, hold the wave low from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable from the prescaler |
| mode_i | input | 4 | Ceiling selection code |
| com_a_i | input | 2 | Channel A output code |
| com_b_i | input | 2 | Channel B output code |
| cmp_a_we_i | input | 1 | Write wdata_i to compare A holding register |
| cmp_b_we_i | input | 1 | Write wdata_i to compare B holding register |
| period_we_i | input | 1 | Write wdata_i to the period register |
| wdata_i | input | 16 | Write data |
| flag_clr_i | input | 4 | Write-one clear: bit 0 wrap, 1 compare A, 2 compare B, 3 period |
| count_o | output | 16 | Counter value |
| wave_a_o | output | 1 | Channel A waveform |
| wave_b_o | output | 1 | Channel B waveform |
| ovf_flag_o | output | 1 | Sticky wrap flag |
| cmpa_flag_o | output | 1 | Sticky compare A hit flag |
| cmpb_flag_o | output | 1 | Sticky compare B hit flag |
| cap_flag_o | output | 1 | Sticky period-register wrap flag |

## Verification
Every result is registered once. The counter, the waves and the flags react to the tick edge and are visible one clock later, a write reaches its register on the edge after the write enable, and a holding value takes effect only at the wrap that follows. The bench reference model steps on the same edge as the design, and all outputs are compared at the falling edge. The directed checks wait for a given count value on the port and sample on the falling edge where the expected level is already settled. This means the one-edge delay, and the extra wrap for buffered writes, are part of each expectation.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    typedef enum logic [1:0] {
        OUT_OFF    = 2'd0,
        OUT_TOGGLE = 2'd1,
        OUT_INV    = 2'd2,
        OUT_NONINV = 2'd3
    } out_code_e;

    localparam logic [3:0] MODE_FIX8   = 4'h5;
    localparam logic [3:0] MODE_FIX9   = 4'h6;
    localparam logic [3:0] MODE_FIX10  = 4'h7;
    localparam logic [3:0] MODE_PERIOD = 4'hE;
    localparam logic [3:0] MODE_CMPA   = 4'hF;

    localparam int NUM_CH    = 2;
    localparam int NUM_FLAGS = 4;
    localparam int FLG_OVF   = 0;
    localparam int FLG_CMPA  = 1;
    localparam int FLG_CMPB  = 2;
    localparam int FLG_PER   = 3;

endpackage

// File: rtl/pwm_top_sel.sv
module pwm_top_sel
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [3:0]       mode_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] cmpa_act_i,
    output logic [CNT_W-1:0] top_o,
    output logic [CNT_W-1:0] wr_mask_o
);
    localparam logic [CNT_W-1:0] LIM8  = CNT_W'((1 << 8) - 1);
    localparam logic [CNT_W-1:0] LIM9  = CNT_W'((1 << 9) - 1);
    localparam logic [CNT_W-1:0] LIM10 = CNT_W'((1 << 10) - 1);

    always_comb begin
        top_o     = '1;
        wr_mask_o = '1;
        case (mode_i)
            MODE_FIX8:   begin top_o = LIM8;  wr_mask_o = LIM8;  end
            MODE_FIX9:   begin top_o = LIM9;  wr_mask_o = LIM9;  end
            MODE_FIX10:  begin top_o = LIM10; wr_mask_o = LIM10; end
            MODE_PERIOD: top_o = period_i;
            MODE_CMPA:   top_o = cmpa_act_i;
            default:     top_o = '1;
        endcase
    end
endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter bit CAN_TOGGLE = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             wrap_i,
    input  logic             toggle_mode_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] wr_mask_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             we_i,
    input  logic [1:0]       com_i,
    output logic [CNT_W-1:0] act_o,
    output logic             hit_o,
    output logic             wave_o
);
    typedef struct packed {
        logic [CNT_W-1:0] hold;
        logic [CNT_W-1:0] act;
        logic             wave;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     hit;

    assign hit = tick_i && (count_i == st_q.act);

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.hold = wdata_i & wr_mask_i;
        end
        if (wrap_i) begin
            st_d.act = st_q.hold;
        end
        case (out_code_e'(com_i))
            OUT_NONINV: begin
                if (wrap_i)   st_d.wave = 1'b1;
                else if (hit) st_d.wave = 1'b0;
            end
            OUT_INV: begin
                if (wrap_i)   st_d.wave = 1'b0;
                else if (hit) st_d.wave = 1'b1;
            end
            OUT_TOGGLE: begin
                if (CAN_TOGGLE && toggle_mode_i) begin
                    if (hit) st_d.wave = !st_q.wave;
                end else begin
                    st_d.wave = 1'b0;
                end
            end
            default: st_d.wave = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o  = st_q.act;
    assign hit_o  = hit;
    assign wave_o = st_q.wave;
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic [3:0]       mode_i,
    input  logic [1:0]       com_a_i,
    input  logic [1:0]       com_b_i,
    input  logic             cmp_a_we_i,
    input  logic             cmp_b_we_i,
    input  logic             period_we_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [3:0]       flag_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wave_a_o,
    output logic             wave_b_o,
    output logic             ovf_flag_o,
    output logic             cmpa_flag_o,
    output logic             cmpb_flag_o,
    output logic             cap_flag_o
);
    typedef struct packed {
        logic [CNT_W-1:0]     cnt;
        logic [CNT_W-1:0]     period;
        logic [NUM_FLAGS-1:0] flags;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    logic [CNT_W-1:0]     top;
    logic [CNT_W-1:0]     wr_mask;
    logic                 at_top;
    logic                 wrap;
    logic [NUM_FLAGS-1:0] flag_set;

    logic [NUM_CH-1:0] ch_we;
    logic [NUM_CH-1:0] ch_hit;
    logic [NUM_CH-1:0] ch_wave;
    logic [1:0]        ch_com [NUM_CH];
    logic [CNT_W-1:0]  ch_act [NUM_CH];

    assign ch_we     = {cmp_b_we_i, cmp_a_we_i};
    assign ch_com[0] = com_a_i;
    assign ch_com[1] = com_b_i;

    pwm_top_sel #(.CNT_W(CNT_W)) u_top_sel (
        .mode_i     (mode_i),
        .period_i   (st_q.period),
        .cmpa_act_i (ch_act[0]),
        .top_o      (top),
        .wr_mask_o  (wr_mask)
    );

    assign at_top = (st_q.cnt == top);
    assign wrap   = tick_i && at_top;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_cmp_chan #(
            .CNT_W      (CNT_W),
            .CAN_TOGGLE (g == 0)
        ) u_chan (
            .clk_i         (clk_i),
            .rst_ni        (rst_ni),
            .tick_i        (tick_i),
            .wrap_i        (wrap),
            .toggle_mode_i (mode_i == MODE_CMPA),
            .count_i       (st_q.cnt),
            .wr_mask_i     (wr_mask),
            .wdata_i       (wdata_i),
            .we_i          (ch_we[g]),
            .com_i         (ch_com[g]),
            .act_o         (ch_act[g]),
            .hit_o         (ch_hit[g]),
            .wave_o        (ch_wave[g])
        );
    end

    always_comb begin
        flag_set           = '0;
        flag_set[FLG_OVF]  = wrap;
        flag_set[FLG_CMPA] = ch_hit[0];
        flag_set[FLG_CMPB] = ch_hit[1];
        flag_set[FLG_PER]  = wrap && (mode_i == MODE_PERIOD);

        st_d = st_q;
        if (tick_i) begin
            st_d.cnt = at_top ? '0 : st_q.cnt + 1'b1;
        end
        if (period_we_i) begin
            st_d.period = wdata_i;
        end
        st_d.flags = (st_q.flags & ~flag_clr_i) | flag_set;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o     = st_q.cnt;
    assign wave_a_o    = ch_wave[0];
    assign wave_b_o    = ch_wave[1];
    assign ovf_flag_o  = st_q.flags[FLG_OVF];
    assign cmpa_flag_o = st_q.flags[FLG_CMPA];
    assign cmpb_flag_o = st_q.flags[FLG_CMPB];
    assign cap_flag_o  = st_q.flags[FLG_PER];
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic [3:0]       mode_i,
    input logic [1:0]       com_b_i,
    input logic [3:0]       flag_clr_i,
    input logic [CNT_W-1:0] count_o,
    input logic             wave_b_o,
    input logic             ovf_flag_o,
    input logic             cap_flag_o
);
    // R2: no tick, no movement
    p_count_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(count_o));

    // R2: a tick either steps by one or returns to zero
    p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> (count_o == CNT_W'($past(count_o) + 1'b1)) || (count_o == '0));

    // R3: the wrap flag only rises together with the counter returning to zero
    p_ovf_on_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovf_flag_o) |-> (count_o == '0));

    // R3: a clear without a tick leaves the wrap flag low
    p_ovf_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_clr_i[0] && !tick_i) |=> !ovf_flag_o);

    // R5: the period flag rises only in the period-register mode
    p_cap_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cap_flag_o) |-> ($past(mode_i) == 4'hE));

    // R12: channel B codes 0 and 1 hold the wave low
    p_b_disc_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (com_b_i < 2'd2) |=> !wave_b_o);
endmodule

bind pwm_timer pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .mode_i     (mode_i),
    .com_b_i    (com_b_i),
    .flag_clr_i (flag_clr_i),
    .count_o    (count_o),
    .wave_b_o   (wave_b_o),
    .ovf_flag_o (ovf_flag_o),
    .cap_flag_o (cap_flag_o)
);

// File: tb/pwm_timer_bench.sv
`timescale 1ns/1ps
module pwm_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  mode = 4'h0;
    logic [1:0]  com_a = 2'd0;
    logic [1:0]  com_b = 2'd0;
    logic        we_a = 1'b0;
    logic        we_b = 1'b0;
    logic        we_p = 1'b0;
    logic [15:0] wdata = 16'h0;
    logic [3:0]  clr = 4'h0;
    logic [15:0] count;
    logic        wave_a, wave_b, f_ovf, f_a, f_b, f_cap;

    always #5 clk = ~clk;

    pwm_timer u_pwm_timer (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_i      (tick),
        .mode_i      (mode),
        .com_a_i     (com_a),
        .com_b_i     (com_b),
        .cmp_a_we_i  (we_a),
        .cmp_b_we_i  (we_b),
        .period_we_i (we_p),
        .wdata_i     (wdata),
        .flag_clr_i  (clr),
        .count_o     (count),
        .wave_a_o    (wave_a),
        .wave_b_o    (wave_b),
        .ovf_flag_o  (f_ovf),
        .cmpa_flag_o (f_a),
        .cmpb_flag_o (f_b),
        .cap_flag_o  (f_cap)
    );

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    done = 0;
    string phase = "R1";

    // reference model state
    int m_cnt = 0, m_per = 0, m_hold_a = 0, m_hold_b = 0, m_act_a = 0, m_act_b = 0;
    bit m_wa = 0, m_wb = 0;
    bit [3:0] m_fl = 0;
    int m_top, m_mask;
    bit m_wrap, m_hit_a, m_hit_b;

    function automatic int ceiling(logic [3:0] md, int per, int acta);
        case (md)
            4'h5: return 'hFF;
            4'h6: return 'h1FF;
            4'h7: return 'h3FF;
            4'hE: return per;
            4'hF: return acta;
            default: return 'hFFFF;
        endcase
    endfunction

    function automatic bit next_wave(bit cur, logic [1:0] code, bit can_tog, bit wr, bit hit);
        case (code)
            2'd3: return wr ? 1'b1 : (hit ? 1'b0 : cur);
            2'd2: return wr ? 1'b0 : (hit ? 1'b1 : cur);
            2'd1: return can_tog ? (hit ? !cur : cur) : 1'b0;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_per = 0; m_hold_a = 0; m_hold_b = 0;
            m_act_a = 0; m_act_b = 0; m_wa = 0; m_wb = 0; m_fl = 0;
        end else begin
            m_top   = ceiling(mode, m_per, m_act_a);
            m_mask  = (mode == 4'h5) ? 'hFF : (mode == 4'h6) ? 'h1FF :
                      (mode == 4'h7) ? 'h3FF : 'hFFFF;
            m_wrap  = tick && (m_cnt == m_top);
            m_hit_a = tick && (m_cnt == m_act_a);
            m_hit_b = tick && (m_cnt == m_act_b);
            m_wa = next_wave(m_wa, com_a, mode == 4'hF, m_wrap, m_hit_a);
            m_wb = next_wave(m_wb, com_b, 1'b0, m_wrap, m_hit_b);
            m_fl = (m_fl & ~clr) | {m_wrap && (mode == 4'hE), m_hit_b, m_hit_a, m_wrap};
            if (m_wrap) begin
                m_act_a = m_hold_a;
                m_act_b = m_hold_b;
            end
            if (we_a) m_hold_a = int'(wdata) & m_mask;
            if (we_b) m_hold_b = int'(wdata) & m_mask;
            if (we_p) m_per = int'(wdata);
            if (tick) m_cnt = m_wrap ? 0 : ((m_cnt + 1) & 'hFFFF);
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s (phase %s) at cycle %0d: actual=%0h expected=%0h",
                     tag, phase, cyc, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 count", int'(count), m_cnt);
            chk("R3 wrap flag", int'(f_ovf), int'(m_fl[0]));
            chk("R4 compare A flag", int'(f_a), int'(m_fl[1]));
            chk("R4 compare B flag", int'(f_b), int'(m_fl[2]));
            chk("R5 period flag", int'(f_cap), int'(m_fl[3]));
            chk("R9 wave A", int'(wave_a), int'(m_wa));
            chk("R9 wave B", int'(wave_b), int'(m_wb));
        end
    end

    task automatic finish_up();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 190000 && !done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual cycle=%0d expected below 190000", cyc);
            finish_up();
        end
    end

    task automatic wait_count(int v);
        do @(negedge clk); while (int'(count) != v);
    endtask

    task automatic wr(int which, int v);
        @(negedge clk);
        wdata = 16'(v);
        we_a = (which == 0);
        we_b = (which == 1);
        we_p = (which == 2);
        @(negedge clk);
        we_a = 0; we_b = 0; we_p = 0;
    endtask

    initial begin
        int ones_a, ones_b, c;
        bit prev;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 count", int'(count), 0);
        chk("R1 waves", int'({wave_a, wave_b}), 0);
        chk("R1 flags", int'({f_ovf, f_a, f_b, f_cap}), 0);
        rst_n = 1;

        // R6 / R9: fixed 8-bit ceiling, masked compare B write
        phase = "R6";
        mode = 4'h5; tick = 1; com_a = 2'd3; com_b = 2'd2;
        wr(0, 'h40);
        wr(1, 'h1F0);
        wait_count('hFF);
        @(negedge clk);
        chk("R2 fixed ceiling wraps to zero", int'(count), 0);
        chk("R3 wrap flag set", int'(f_ovf), 1);
        wait_count('h41);
        chk("R9 non-inverting low after hit", int'(wave_a), 0);
        wait_count('hF0);
        chk("R6 masked compare B before hit", int'(wave_b), 0);
        @(negedge clk);
        chk("R6 masked compare B hit at 0xF0", int'(wave_b), 1);
        wait_count('h10);
        chk("R9 non-inverting high after wrap", int'(wave_a), 1);
        chk("R9 inverting low after wrap", int'(wave_b), 0);
        clr = 4'hF;
        @(negedge clk);
        clr = 4'h0;
        chk("R3 flag cleared", int'(f_ovf), 0);

        // R2: gated ticks, 9-bit ceiling
        phase = "R2";
        mode = 4'h6;
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            tick = (i % 3) != 0;
            clr = (i % 97 == 0) ? 4'hF : 4'h0;
        end
        clr = 0; tick = 0;
        @(negedge clk);
        c = int'(count);
        repeat (5) @(negedge clk);
        chk("R2 holds without tick", int'(count), c);
        tick = 1;
        mode = 4'h7;
        repeat (1100) @(negedge clk);
        mode = 4'h3;
        repeat (40) @(negedge clk);
        mode = 4'h7;

        // R5 / R7: period register ceiling, buffered compare A
        phase = "R7";
        wr(2, 100);
        wait_count(0);
        mode = 4'hE;
        wr(0, 30);
        wait_count(100);
        @(negedge clk);
        chk("R5 period flag on wrap", int'(f_cap), 1);
        wait_count(10);
        wr(0, 50);
        wait_count(31);
        chk("R7 old compare still active", int'(wave_a), 0);
        wait_count(100);
        wait_count(31);
        chk("R7 new compare not yet hit", int'(wave_a), 1);
        wait_count(51);
        chk("R7 new compare active after wrap", int'(wave_a), 0);

        // R8: period written below the count
        phase = "R8";
        wait_count(50);
        wr(2, 10);
        clr = 4'h1;
        @(negedge clk);
        clr = 4'h0;
        wait_count('hFFFF);
        @(negedge clk);
        chk("R8 rollover to zero", int'(count), 0);
        chk("R8 rollover sets no wrap flag", int'(f_ovf), 0);
        wait_count(10);
        @(negedge clk);
        chk("R8 new ceiling wraps", int'(count), 0);
        chk("R8 wrap flag at new ceiling", int'(f_ovf), 1);

        // R10: duty extremes
        phase = "R10";
        wr(2, 20);
        wr(0, 20);
        wr(1, 0);
        com_b = 2'd3;
        wait_count(20);
        wait_count(20);
        ones_a = 0; ones_b = 0;
        for (int i = 0; i < 21; i++) begin
            @(negedge clk);
            ones_a += int'(wave_a);
            ones_b += int'(wave_b);
        end
        chk("R10 zero compare gives one-count spike", ones_b, 1);
        chk("R10 compare at ceiling stays high", ones_a, 21);

        // R11: toggle on compare A in mode 0xF
        phase = "R11";
        com_a = 2'd1;
        mode = 4'hF;
        wr(1, 2);
        wr(0, 5);
        wait_count(20);
        wait_count(5);
        ones_a = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            ones_a += int'(wave_a);
        end
        chk("R11 half duty over 2(TOP+1)", ones_a, 6);
        wr(0, 0);
        wait_count(5);
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            prev = wave_a;
            @(negedge clk);
            chk("R11 inverts every tick", int'(wave_a), int'(!prev));
        end

        // R12: disconnected codes
        phase = "R12";
        com_b = 2'd1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R12 code 1 on channel B low", int'(wave_b), 0);
        end
        mode = 4'hE;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R12 toggle outside mode 0xF low", int'(wave_a), 0);
        end
        com_a = 2'd0; com_b = 2'd0;
        repeat (30) @(negedge clk);
        chk("R12 code 0 low", int'({wave_a, wave_b}), 0);
        finish_up();
    end
endmodule